// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt status flags of a four-channel capture/compare timer that also has a 16-bit pulse accumulator and a free-running counter. Single-cycle event strobes from the channels, from the accumulator (wrap and input edge) and from the counter overflow set sticky flags. Each flag has its own enable bit, and the block drives one registered interrupt request per source.

Software reaches the flags over a small register bus with address, write strobe, read strobe and write data. Read data is combinational from the address. Flags are normally cleared by writing 1 to them. With the fast-clear mode bit set, ordinary data accesses clear flags as a side effect. An access to a channel's capture/compare data slot clears that channel's flag. An access to either pulse accumulator counter slot clears both accumulator flags. The data behind those slots belongs to the timer datapath, so this block returns 0 there.

Top module: `tmrIrqFlags`

## Requirements
- R1: A one-cycle pulse on `chEvt[n]` makes channel flag n read as 1 from the next cycle on. A flag that is already set stays set, and later pulses are still accepted.
- R2: Address 0x0 holds the channel flags in bits [3:0], with bit n for channel n. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R3: Address 0x5 bit 0 is the fast-clear mode bit. When it is 1, a read or a write of address 0x8+n clears channel flag n and no other flag. When it is 0, such accesses change no flag.
- R4: Address 0x2 holds the accumulator flags: bit 0 is set by `paOvfEvt`, which pulses when the 16-bit accumulator wraps from 0xFFFF to 0x0000, and bit 1 is set by `paEdgeEvt`. Both bits clear when 1 is written to them.
- R5: In fast-clear mode, any read or write of address 0xC or 0xD clears both accumulator flags and leaves the channel and counter flags alone. With the mode off, these accesses clear nothing.
- R6: Address 0x3 bit 0 is the counter overflow flag. It is set by `cntOvfEvt` and cleared by writing 1 to it.
- R7: Address 0x1 bits [3:0] hold the channel enables. Address 0x4 holds the other enables: bit 0 for accumulator overflow, bit 1 for accumulator edge, bit 2 for counter overflow. All of them read back as written.
- R8: Each request output is 1 exactly when its flag and its enable were both 1 in the previous cycle, so a request follows a flag or enable change one cycle later.
- R9: If a set event and a clear (by write-1 or by fast-clear access) reach the same flag in one cycle, the flag ends up set.
- R10: Reset clears all flags, all enables and the fast-clear mode bit, and drives all request outputs low.
- R11: Unused bits of mapped registers read as 0. Unmapped addresses and the data slots 0x8 to 0xD read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| chEvt | input | 4 | Capture/compare event pulse per channel |
| paOvfEvt | input | 1 | Accumulator wrap pulse |
| paEdgeEvt | input | 1 | Accumulator input edge pulse |
| cntOvfEvt | input | 1 | Free-running counter overflow pulse |
| chIrq | output | 4 | Channel interrupt requests |
| paOvfIrq | output | 1 | Accumulator overflow request |
| paEdgeIrq | output | 1 | Accumulator edge request |
| cntOvfIrq | output | 1 | Counter overflow request |

## Verification
A new set event and a clear of the same flag can fall in one cycle. The clear can be a write-1 to the flag register or a fast-clear access to a data slot. The bench drives an event pulse in the same cycle as a write-1 to the flag register, and again in the same cycle as a fast-clear access to an accumulator counter slot. It then reads the flags back and expects the pulsed flags to be set and every other flag cleared. Exhaustive sweeps of flag patterns against write-1 masks, and of flag patterns against enable masks, cover the clear and request paths around that collision.

// File: rtl/tifPkg.sv
package tifPkg;
  localparam int CH_N  = 4;
  localparam int PA_N  = 2;
  localparam int AUX_N = 3;

  localparam int A_CHFLG  = 0;
  localparam int A_CHEN   = 1;
  localparam int A_PAFLG  = 2;
  localparam int A_CNTFLG = 3;
  localparam int A_AUXEN  = 4;
  localparam int A_CTRL   = 5;
  localparam int A_CHDAT  = 8;
  localparam int A_PACHI  = 12;
  localparam int A_PACLO  = 13;

  typedef struct packed {
    logic [CH_N-1:0] chClr;
    logic [PA_N-1:0] paClr;
    logic            cntClr;
  } clrStrobe_t;
endpackage

// File: rtl/tifCtrl.sv
module tifCtrl
  import tifPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CH_N-1:0]   chFlag,
  input  logic [PA_N-1:0]   paFlag,
  input  logic              cntFlag,
  output logic [CH_N-1:0]   chEn,
  output logic [AUX_N-1:0]  auxEn,
  output clrStrobe_t        clr,
  output logic [DATA_W-1:0] busRdata
);
  logic              fastQ;
  logic              busAcc;
  logic              paCntHit;
  logic [CH_N-1:0]   chDatHit;
  logic              unusedWdata;

  assign busAcc      = busWr | busRd;
  assign paCntHit    = (busAddr == ADDR_W'(A_PACHI)) || (busAddr == ADDR_W'(A_PACLO));
  assign unusedWdata = ^busWdata[DATA_W-1:CH_N];

  for (genvar n = 0; n < CH_N; n++) begin : g_hit
    assign chDatHit[n] = (busAddr == ADDR_W'(A_CHDAT + n));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chEn  <= '0;
      auxEn <= '0;
      fastQ <= 1'b0;
    end else if (busWr) begin
      if (busAddr == ADDR_W'(A_CHEN))  chEn  <= busWdata[CH_N-1:0];
      if (busAddr == ADDR_W'(A_AUXEN)) auxEn <= busWdata[AUX_N-1:0];
      if (busAddr == ADDR_W'(A_CTRL))  fastQ <= busWdata[0];
    end
  end

  always_comb begin
    clr = '0;
    if (busWr && busAddr == ADDR_W'(A_CHFLG))  clr.chClr  = busWdata[CH_N-1:0];
    if (busWr && busAddr == ADDR_W'(A_PAFLG))  clr.paClr  = busWdata[PA_N-1:0];
    if (busWr && busAddr == ADDR_W'(A_CNTFLG)) clr.cntClr = busWdata[0];
    if (fastQ && busAcc) begin
      clr.chClr = clr.chClr | chDatHit;
      if (paCntHit) clr.paClr = '1;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(A_CHFLG):  busRdata[CH_N-1:0]  = chFlag;
      ADDR_W'(A_CHEN):   busRdata[CH_N-1:0]  = chEn;
      ADDR_W'(A_PAFLG):  busRdata[PA_N-1:0]  = paFlag;
      ADDR_W'(A_CNTFLG): busRdata[0]         = cntFlag;
      ADDR_W'(A_AUXEN):  busRdata[AUX_N-1:0] = auxEn;
      ADDR_W'(A_CTRL):   busRdata[0]         = fastQ;
      default: ;
    endcase
  end

  // R3: with fast-clear off, nothing but a write may raise a clear strobe
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!fastQ && !busWr) |-> (clr == '0));
  // R5: fast-clear off, an accumulator slot access clears no accumulator flag
  p_pa_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fastQ && paCntHit) |-> (clr.paClr == '0));
endmodule

// File: rtl/tifFlags.sv
module tifFlags
  import tifPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CH_N-1:0]  chEvt,
  input  logic             paOvfEvt,
  input  logic             paEdgeEvt,
  input  logic             cntOvfEvt,
  input  clrStrobe_t       clr,
  input  logic [CH_N-1:0]  chEn,
  input  logic [AUX_N-1:0] auxEn,
  output logic [CH_N-1:0]  chFlag,
  output logic [PA_N-1:0]  paFlag,
  output logic             cntFlag,
  output logic [CH_N-1:0]  chIrq,
  output logic [AUX_N-1:0] auxIrq
);
  logic [PA_N-1:0] paSet;
  assign paSet = {paEdgeEvt, paOvfEvt};

  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) chFlag[n] <= 1'b0;
      else       chFlag[n] <= chEvt[n] | (chFlag[n] & ~clr.chClr[n]);
    end

    // R1: an event always leaves the flag set
    p_set_r1: assert property (@(posedge clk) disable iff (!rstN)
      chEvt[n] |=> chFlag[n]);
    // R9: event beats a clear in the same cycle
    p_setwins_r9: assert property (@(posedge clk) disable iff (!rstN)
      (chEvt[n] && clr.chClr[n]) |=> chFlag[n]);
    // R2: a clear with no event drops the flag
    p_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
      (clr.chClr[n] && !chEvt[n]) |=> !chFlag[n]);
    // R8: request follows flag and enable one cycle later
    p_irq_on_r8: assert property (@(posedge clk) disable iff (!rstN)
      (chFlag[n] && chEn[n]) |=> chIrq[n]);
    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rstN)
      !chFlag[n] |=> !chIrq[n]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paFlag  <= '0;
      cntFlag <= 1'b0;
      chIrq   <= '0;
      auxIrq  <= '0;
    end else begin
      paFlag  <= paSet | (paFlag & ~clr.paClr);
      cntFlag <= cntOvfEvt | (cntFlag & ~clr.cntClr);
      chIrq   <= chFlag & chEn;
      auxIrq  <= {cntFlag, paFlag} & auxEn;
    end
  end

  // R4: accumulator overflow flag clear with no new wrap
  p_pa_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clr.paClr[0] && !paOvfEvt) |=> !paFlag[0]);
  // R6: counter flag holds when neither set nor cleared
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cntOvfEvt && !clr.cntClr) |=> $stable(cntFlag));
endmodule

// File: rtl/tmrIrqFlags.sv
module tmrIrqFlags
  import tifPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CH_N-1:0]   chEvt,
  input  logic              paOvfEvt,
  input  logic              paEdgeEvt,
  input  logic              cntOvfEvt,
  output logic [CH_N-1:0]   chIrq,
  output logic              paOvfIrq,
  output logic              paEdgeIrq,
  output logic              cntOvfIrq
);
  clrStrobe_t       clr;
  logic [CH_N-1:0]  chFlag;
  logic [PA_N-1:0]  paFlag;
  logic             cntFlag;
  logic [CH_N-1:0]  chEn;
  logic [AUX_N-1:0] auxEn;
  logic [AUX_N-1:0] auxIrq;

  tifCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .chFlag(chFlag), .paFlag(paFlag), .cntFlag(cntFlag),
    .chEn(chEn), .auxEn(auxEn), .clr(clr), .busRdata(busRdata)
  );

  tifFlags u_flags (
    .clk(clk), .rstN(rstN), .chEvt(chEvt), .paOvfEvt(paOvfEvt),
    .paEdgeEvt(paEdgeEvt), .cntOvfEvt(cntOvfEvt), .clr(clr), .chEn(chEn),
    .auxEn(auxEn), .chFlag(chFlag), .paFlag(paFlag), .cntFlag(cntFlag),
    .chIrq(chIrq), .auxIrq(auxIrq)
  );

  assign paOvfIrq  = auxIrq[0];
  assign paEdgeIrq = auxIrq[1];
  assign cntOvfIrq = auxIrq[2];
endmodule

// File: tb/test_tmrIrqFlags.sv
`timescale 1ns/1ps
module test_tmrIrqFlags;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] chEvt = '0;
  logic       paOvfEvt = 1'b0;
  logic       paEdgeEvt = 1'b0;
  logic       cntOvfEvt = 1'b0;
  logic [3:0] chIrq;
  logic       paOvfIrq, paEdgeIrq, cntOvfIrq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tmrIrqFlags i_tmrIrqFlags (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .chEvt(chEvt), .paOvfEvt(paOvfEvt),
    .paEdgeEvt(paEdgeEvt), .cntOvfEvt(cntOvfEvt), .chIrq(chIrq),
    .paOvfIrq(paOvfIrq), .paEdgeIrq(paEdgeIrq), .cntOvfIrq(cntOvfIrq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus/event cycle, starting and ending at a falling edge
  task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d,
                     input logic [3:0] ce, input logic po, input logic pe, input logic co,
                     output logic [7:0] q);
    busAddr = a; busWr = w; busRd = r; busWdata = d;
    chEvt = ce; paOvfEvt = po; paEdgeEvt = pe; cntOvfEvt = co;
    #1 q = busRdata;
    @(negedge clk);
    busWr = 0; busRd = 0; chEvt = '0; paOvfEvt = 0; paEdgeEvt = 0; cntOvfEvt = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    cyc(a, 1, 0, d, 4'h0, 0, 0, 0, q);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    cyc(a, 0, 1, 8'h00, 4'h0, 0, 0, 0, q);
  endtask

  task automatic evt(input logic [3:0] ce, input logic po, input logic pe, input logic co);
    logic [7:0] q;
    cyc(4'h7, 0, 0, 8'h00, ce, po, pe, co, q);
  endtask

  task automatic clearAll();
    wr(4'h0, 8'h0F); wr(4'h2, 8'h03); wr(4'h3, 8'h01);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), q); chk("R10 reg after reset", q, 8'h00);
    end
    chk("R10 irq after reset", {1'b0, cntOvfIrq, paEdgeIrq, paOvfIrq, chIrq}, 8'h00);

    // R1/R2: every flag pattern against every write-1 mask
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 16; w++) begin
        wr(4'h0, 8'h0F);
        evt(4'(s), 0, 0, 0);
        rd(4'h0, q); chk("R1 set pattern", q, 8'(s));
        wr(4'h0, 8'(w));
        rd(4'h0, q); chk("R2 write-1 clear", q, 8'(s & ~w));
      end
    end

    // R1: repeated events on a set flag
    wr(4'h0, 8'h0F);
    evt(4'h4, 0, 0, 0); evt(4'h4, 0, 0, 0);
    rd(4'h0, q); chk("R1 repeated event", q, 8'h04);
    wr(4'h0, 8'h04); evt(4'h4, 0, 0, 0);
    rd(4'h0, q); chk("R1 event after clear", q, 8'h04);

    // R9: event and write-1 in the same cycle
    evt(4'hF, 0, 0, 0);
    cyc(4'h0, 1, 0, 8'h0F, 4'h5, 0, 0, 0, q);
    rd(4'h0, q); chk("R9 set wins over write-1", q, 8'h05);

    // R11: unused bits and unmapped addresses
    evt(4'hF, 0, 0, 0);
    wr(4'h0, 8'hF0);
    rd(4'h0, q); chk("R11 upper bits read 0, R2 zero write keeps", q, 8'h0F);
    for (int a = 6; a < 16; a++) begin
      rd(4'(a), q); chk("R11 unmapped/data slot reads 0", q, 8'h00);
    end
    rd(4'h0, q); chk("R3 mode off: slot reads clear nothing", q, 8'h0F);

    // R3: fast-clear by channel slot access
    for (int m = 0; m < 2; m++) begin
      wr(4'h5, 8'(m));
      for (int n = 0; n < 4; n++) begin
        for (int op = 0; op < 2; op++) begin
          evt(4'hF, 0, 0, 0);
          cyc(4'(8 + n), op[0], !op[0], 8'h00, 4'h0, 0, 0, 0, q);
          rd(4'h0, q);
          chk("R3 channel slot access", q, (m == 1) ? 8'(4'hF & ~(4'h1 << n)) : 8'h0F);
        end
      end
    end
    wr(4'h5, 8'h00);

    // R4: accumulator flags
    clearAll();
    evt(4'h0, 1, 0, 0);
    rd(4'h2, q); chk("R4 wrap sets bit0", q, 8'h01);
    evt(4'h0, 0, 1, 0);
    rd(4'h2, q); chk("R4 edge sets bit1", q, 8'h03);
    wr(4'h2, 8'h00);
    rd(4'h2, q); chk("R4 zero write keeps", q, 8'h03);
    wr(4'h2, 8'h01);
    rd(4'h2, q); chk("R4 clear bit0", q, 8'h02);
    wr(4'h2, 8'h02);
    rd(4'h2, q); chk("R4 clear bit1", q, 8'h00);

    // R5: fast-clear by accumulator counter access
    for (int m = 0; m < 2; m++) begin
      wr(4'h5, 8'(m));
      for (int a = 12; a < 14; a++) begin
        for (int op = 0; op < 2; op++) begin
          evt(4'hF, 1, 1, 1);
          cyc(4'(a), op[0], !op[0], 8'h55, 4'h0, 0, 0, 0, q);
          rd(4'h2, q); chk("R5 accumulator flags", q, (m == 1) ? 8'h00 : 8'h03);
          rd(4'h0, q); chk("R5 channel flags untouched", q, 8'h0F);
          rd(4'h3, q); chk("R5 counter flag untouched", q, 8'h01);
        end
      end
    end
    // R9: accumulator wrap during a fast-clear access
    evt(4'h0, 1, 1, 0);
    cyc(4'hC, 0, 1, 8'h00, 4'h0, 1, 0, 0, q);
    rd(4'h2, q); chk("R9 set wins over fast clear", q, 8'h01);
    wr(4'h5, 8'h00);

    // R6: counter overflow flag
    clearAll();
    evt(4'h0, 0, 0, 1);
    rd(4'h3, q); chk("R6 overflow sets", q, 8'h01);
    wr(4'h3, 8'h00);
    rd(4'h3, q); chk("R6 zero write keeps", q, 8'h01);
    wr(4'h3, 8'h01);
    rd(4'h3, q); chk("R6 write-1 clears", q, 8'h00);

    // R7/R11: enable and control readback
    wr(4'h1, 8'hFA); rd(4'h1, q); chk("R7 channel enables", q, 8'h0A);
    wr(4'h4, 8'hFD); rd(4'h4, q); chk("R7 aux enables", q, 8'h05);
    wr(4'h5, 8'hFE); rd(4'h5, q); chk("R11 control unused bits", q, 8'h00);

    // R8: channel requests, every flag pattern against every enable mask
    for (int e = 0; e < 16; e++) begin
      for (int f = 0; f < 16; f++) begin
        clearAll();
        wr(4'h1, 8'(e));
        evt(4'(f), 0, 0, 0);
        chk("R8 request latency", {4'h0, chIrq}, 8'h00);
        evt(4'h0, 0, 0, 0);
        chk("R8 channel request", {4'h0, chIrq}, 8'(e & f));
      end
    end
    wr(4'h1, 8'h00);

    // R8: auxiliary requests
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        clearAll();
        wr(4'h4, 8'(e));
        evt(4'h0, f[0], f[1], f[2]);
        chk("R8 aux latency", {5'h0, cntOvfIrq, paEdgeIrq, paOvfIrq}, 8'h00);
        evt(4'h0, 0, 0, 0);
        chk("R8 aux request", {5'h0, cntOvfIrq, paEdgeIrq, paOvfIrq}, 8'(e & f));
      end
    end
    // R8: dropping the enable drops the request one cycle later
    wr(4'h4, 8'h00);
    chk("R8 enable off takes a cycle", {5'h0, cntOvfIrq, paEdgeIrq, paOvfIrq}, 8'h07);
    evt(4'h0, 0, 0, 0);
    chk("R8 enable off", {5'h0, cntOvfIrq, paEdgeIrq, paOvfIrq}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule